// File: doc/BRIEF.md
# Register-Relative Operand Fetch Unit

This unit turns a 6-bit operand specifier into an operand value for a 16-bit register-based processor. The upper three specifier bits choose one of eight addressing modes. The lower three bits name one of eight 16-bit registers, and the last of these registers serves as the program counter. Memory is byte addressed with two bytes per word. The unit reaches it through a single read port that carries one request at a time: a request pulse with an address, followed later by a data-valid pulse with the word.

A fetch starts with a one-cycle start strobe that carries the specifier. The unit then walks a chain of zero to three memory reads that the mode defines. It ends with a one-cycle done pulse that carries the effective address and the operand. The modes are direct, indirect, auto-increment, auto-decrement, deferred, auto-increment deferred, indexed and indexed-deferred. The indexed modes fetch an offset word at the program counter, so naming the program counter as the index register gives PC-relative operands. The side effects of each mode (step up, step down, program counter advance) are written to the registers on the same clock edge that raises done. A separate write port lets the surrounding pipeline load register values while the unit is idle.

Top module: `opfetch_unit`

## Requirements
- R1: After reset, `done`, `busy` and `mem_req` are low, and every register reads back as zero.
- R2: `spec[5:3]` is the mode and `spec[2:0]` the register, where register 7 is the program counter. Mode 0 returns the register contents with `eff_addr` = 0 and makes no memory read. `done` is high in the cycle right after the start cycle.
- R3: Mode 1 makes one read at the register value. The operand is the word read and `eff_addr` is the register value. No register changes.
- R4: Mode 2 behaves like mode 1, and the register then holds its old value plus 2 once `done` is high.
- R5: Mode 6 first forms the register value minus 2, with 16-bit wraparound. It reads the operand there, reports that address as `eff_addr` and leaves that value in the register.
- R6: Mode 4 reads the word at the register value and uses that word as the operand address for a second read. `eff_addr` is the second address.
- R7: Mode 5 behaves like mode 4, and the register then holds its old value plus 2.
- R8: Mode 3 reads a 16-bit two's-complement offset at the program counter and adds it to the register value, modulo 2^16. It reads the operand at the sum and advances the program counter by 2.
- R9: Mode 7 forms the same sum as mode 3, reads the operand address from that location, then reads the operand. The program counter advances by 2.
- R10: When register 7 is the index in modes 3 and 7, the base added to the offset is the program counter already advanced past the offset word.
- R11: While `busy` is high, `start` and `wr_en` have no effect.
- R12: Each read is one `mem_req` pulse, and no new request is made until `mem_rvalid` answers it. Reads occur in the order the mode defines. `done` is one cycle wide and only occurs when `busy` is low, and `busy` covers every fetch that makes a memory read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a fetch with `spec` (ignored while busy) |
| spec | input | 6 | Mode in [5:3], register in [2:0] |
| wr_en | input | 1 | Register load strobe (honoured only while idle) |
| wr_sel | input | 3 | Register to load |
| wr_data | input | 16 | Value to load |
| mem_req | output | 1 | One-cycle word read request |
| mem_addr | output | 16 | Byte address of the read |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 16 | Read data word |
| busy | output | 1 | A fetch with memory reads is in progress |
| done | output | 1 | One-cycle completion pulse |
| eff_addr | output | 16 | Effective address of the operand |
| operand | output | 16 | Operand value |

## Verification
The assertions assume that the memory answers each request with exactly one `mem_rvalid` pulse, at least one cycle later, and never raises `mem_rvalid` without a request pending. They also assume that a register load never arrives in the same cycle as a start. The bench memory model holds a single pending request, and its latency is set per phase from zero to six cycles. Register loads go only between fetches, except in the deliberate busy-time injections that R11 targets.

// File: rtl/opf_pkg.sv
// Package: shared types for the operand fetch unit.
// Assumes three mode bits, so exactly eight addressing modes exist.
package opf_pkg;

    // Addressing mode codes carried in the upper specifier field.
    typedef enum logic [2:0] {
        AM_REG    = 3'd0,
        AM_IND    = 3'd1,
        AM_INC    = 3'd2,
        AM_IDX    = 3'd3,
        AM_DEF    = 3'd4,
        AM_INCDEF = 3'd5,
        AM_DEC    = 3'd6,
        AM_IDXDEF = 3'd7
    } amode_t;

    // Sequencer phases: idle, offset read, pointer read, operand read.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_OFS  = 2'd1,
        ST_PTR  = 2'd2,
        ST_OPD  = 2'd3
    } fstate_t;

endpackage

// File: rtl/opf_regfile.sv
// Module: register file of the operand fetch unit.
// Holds NREG registers of W bits, the last being the program counter.
// Assumes the sequencer's update port is only active while busy, and
// that the external load port is honoured only while idle.
module opf_regfile #(
    parameter int W     = 16,
    parameter int NREG  = 8,
    parameter int SEL_W = $clog2(NREG)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     busy,
    input  logic                     wr_en,
    input  logic [SEL_W-1:0]         wr_sel,
    input  logic [W-1:0]             wr_data,
    input  logic                     upd_en,
    input  logic [SEL_W-1:0]         upd_sel,
    input  logic [W-1:0]             upd_data,
    input  logic [SEL_W-1:0]         rd_sel,
    output logic [W-1:0]             rd_data,
    output logic [W-1:0]             pc_data,
    output logic [NREG-1:0][W-1:0]   regs_o
);

    localparam int PC_IDX = NREG - 1;

    logic [W-1:0] regs_q [NREG];

    for (genvar i = 0; i < NREG; i++) begin : g_reg
        // One register: a mode side effect wins over an idle-time load.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                regs_q[i] <= '0;
            end else if (upd_en && upd_sel == SEL_W'(i)) begin
                regs_q[i] <= upd_data;
            end else if (wr_en && !busy && wr_sel == SEL_W'(i)) begin
                regs_q[i] <= wr_data;
            end
        end
    end

    // Flatten the array for reads and for checks in the parent.
    always_comb begin
        for (int k = 0; k < NREG; k++) begin
            regs_o[k] = regs_q[k];
        end
    end

    assign rd_data = regs_q[rd_sel];
    assign pc_data = regs_q[PC_IDX];

    // R11: a load presented while busy leaves all registers untouched.
    p_busy_wr_ignored_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !upd_en) |=> $stable(regs_o));

endmodule

// File: rtl/opf_agu.sv
// Module: address arithmetic for the operand fetch unit.
// Purely combinational; forms the word steps and the indexed sum.
// Assumes byte addressing with W/8 bytes per word.
module opf_agu #(
    parameter int W = 16
) (
    input  logic [W-1:0] base,
    input  logic [W-1:0] pc,
    input  logic [W-1:0] offset,
    input  logic         sel_is_pc,
    output logic [W-1:0] step_up,
    output logic [W-1:0] step_down,
    output logic [W-1:0] pc_next,
    output logic [W-1:0] index_ea
);

    localparam int STEP = W / 8;

    logic [W-1:0] idx_base;

    // Word steps of the selected register and of the program counter.
    always_comb begin
        step_up   = base + W'(STEP);
        step_down = base - W'(STEP);
        pc_next   = pc + W'(STEP);
    end

    // Indexed sum: the PC as index is taken past its offset word.
    always_comb begin
        idx_base = sel_is_pc ? pc_next : base;
        index_ea = idx_base + offset;
    end

endmodule

// File: rtl/opf_seq.sv
// Module: sequencer of the operand fetch unit.
// Walks the read chain of the captured mode, one request at a time,
// and raises done with the results and the register side effect.
// Assumes exactly one mem_rvalid per request, never unsolicited, and
// that registers do not change while busy except through this block.
module opf_seq
    import opf_pkg::*;
#(
    parameter int W     = 16,
    parameter int NREG  = 8,
    parameter int SEL_W = $clog2(NREG)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [2:0]       spec_mode,
    input  logic [SEL_W-1:0] spec_sel,
    output logic [SEL_W-1:0] rd_sel,
    input  logic [W-1:0]     rd_val,
    input  logic [W-1:0]     pc_val,
    input  logic [W-1:0]     step_up,
    input  logic [W-1:0]     step_down,
    input  logic [W-1:0]     pc_next,
    input  logic [W-1:0]     index_ea,
    output logic             mem_req,
    output logic [W-1:0]     mem_addr,
    input  logic             mem_rvalid,
    input  logic [W-1:0]     mem_rdata,
    output logic             busy,
    output logic             done,
    output logic [W-1:0]     eff_addr,
    output logic [W-1:0]     operand,
    output logic             upd_en,
    output logic [SEL_W-1:0] upd_sel,
    output logic [W-1:0]     upd_data,
    output amode_t           cur_mode,
    output logic [SEL_W-1:0] cur_sel
);

    localparam logic [SEL_W-1:0] PC_SEL = SEL_W'(NREG - 1);

    fstate_t          st_q;
    amode_t           mode_q;
    amode_t           new_mode;
    logic [SEL_W-1:0] sel_q;
    logic             issued_q;
    logic [W-1:0]     addr_q;
    logic [W-1:0]     ea_q;
    logic [W-1:0]     opnd_q;
    logic             done_q;
    logic             accept;

    assign new_mode = amode_t'(spec_mode);
    assign busy     = (st_q != ST_IDLE);
    assign mem_req  = busy && !issued_q;
    assign mem_addr = addr_q;
    assign accept   = busy && issued_q && mem_rvalid;
    assign rd_sel   = busy ? sel_q : spec_sel;
    assign done     = done_q;
    assign eff_addr = ea_q;
    assign operand  = opnd_q;
    assign cur_mode = mode_q;
    assign cur_sel  = sel_q;

    // Phase, address and result registers of the read chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= ST_IDLE;
            mode_q   <= AM_REG;
            sel_q    <= '0;
            issued_q <= 1'b0;
            addr_q   <= '0;
            ea_q     <= '0;
            opnd_q   <= '0;
            done_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (mem_req) begin
                issued_q <= 1'b1;
            end
            case (st_q)
                ST_IDLE: begin
                    if (start) begin
                        mode_q   <= new_mode;
                        sel_q    <= spec_sel;
                        issued_q <= 1'b0;
                        case (new_mode)
                            AM_REG: begin
                                done_q <= 1'b1;
                                opnd_q <= rd_val;
                                ea_q   <= '0;
                            end
                            AM_IND, AM_INC: begin
                                addr_q <= rd_val;
                                st_q   <= ST_OPD;
                            end
                            AM_DEF, AM_INCDEF: begin
                                addr_q <= rd_val;
                                st_q   <= ST_PTR;
                            end
                            AM_DEC: begin
                                addr_q <= step_down;
                                st_q   <= ST_OPD;
                            end
                            default: begin
                                addr_q <= pc_val;
                                st_q   <= ST_OFS;
                            end
                        endcase
                    end
                end
                ST_OFS: begin
                    if (accept) begin
                        addr_q   <= index_ea;
                        issued_q <= 1'b0;
                        st_q     <= (mode_q == AM_IDXDEF) ? ST_PTR : ST_OPD;
                    end
                end
                ST_PTR: begin
                    if (accept) begin
                        addr_q   <= mem_rdata;
                        issued_q <= 1'b0;
                        st_q     <= ST_OPD;
                    end
                end
                default: begin
                    if (accept) begin
                        opnd_q   <= mem_rdata;
                        ea_q     <= addr_q;
                        done_q   <= 1'b1;
                        issued_q <= 1'b0;
                        st_q     <= ST_IDLE;
                    end
                end
            endcase
        end
    end

    // Side effect of the mode, written on the edge that raises done.
    always_comb begin
        upd_en   = 1'b0;
        upd_sel  = sel_q;
        upd_data = step_up;
        if (st_q == ST_OPD && accept) begin
            case (mode_q)
                AM_INC, AM_INCDEF: begin
                    upd_en   = 1'b1;
                    upd_data = step_up;
                end
                AM_DEC: begin
                    upd_en   = 1'b1;
                    upd_data = step_down;
                end
                AM_IDX, AM_IDXDEF: begin
                    upd_en   = 1'b1;
                    upd_sel  = PC_SEL;
                    upd_data = pc_next;
                end
                default: upd_en = 1'b0;
            endcase
        end
    end

    // R12: a request lasts one cycle and is not repeated before its answer.
    p_req_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> !mem_req);

    // R12: completion is only reported once the chain has ended.
    p_done_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R12: the address holds steady while a read is outstanding.
    p_addr_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !mem_req && !mem_rvalid) |=> $stable(mem_addr));

endmodule

// File: rtl/opfetch_unit.sv
// Module: register-relative operand fetch unit (top).
// Resolves a mode/register specifier into an effective address and an
// operand, through a single-outstanding word read port.
// Assumes the memory answers every request exactly once, at least one
// cycle later, and that loads and starts do not share a cycle.
module opfetch_unit
    import opf_pkg::*;
#(
    parameter int W    = 16,
    parameter int NREG = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        start,
    input  logic [3+$clog2(NREG)-1:0]   spec,
    input  logic                        wr_en,
    input  logic [$clog2(NREG)-1:0]     wr_sel,
    input  logic [W-1:0]                wr_data,
    output logic                        mem_req,
    output logic [W-1:0]                mem_addr,
    input  logic                        mem_rvalid,
    input  logic [W-1:0]                mem_rdata,
    output logic                        busy,
    output logic                        done,
    output logic [W-1:0]                eff_addr,
    output logic [W-1:0]                operand
);

    localparam int SEL_W  = $clog2(NREG);
    localparam int STEP   = W / 8;
    localparam int PC_IDX = NREG - 1;

    logic [SEL_W-1:0]       rd_sel;
    logic [W-1:0]           rd_val;
    logic [W-1:0]           pc_val;
    logic [W-1:0]           step_up;
    logic [W-1:0]           step_down;
    logic [W-1:0]           pc_next;
    logic [W-1:0]           index_ea;
    logic                   sel_is_pc;
    logic                   upd_en;
    logic [SEL_W-1:0]       upd_sel;
    logic [W-1:0]           upd_data;
    amode_t                 cur_mode;
    logic [SEL_W-1:0]       cur_sel;
    logic [NREG-1:0][W-1:0] regs_all;
    logic [W-1:0]           cur_val;

    assign sel_is_pc = (rd_sel == SEL_W'(PC_IDX));
    assign cur_val   = regs_all[cur_sel];

    opf_regfile #(.W(W), .NREG(NREG), .SEL_W(SEL_W)) rf_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .busy     (busy),
        .wr_en    (wr_en),
        .wr_sel   (wr_sel),
        .wr_data  (wr_data),
        .upd_en   (upd_en),
        .upd_sel  (upd_sel),
        .upd_data (upd_data),
        .rd_sel   (rd_sel),
        .rd_data  (rd_val),
        .pc_data  (pc_val),
        .regs_o   (regs_all)
    );

    opf_agu #(.W(W)) agu_i (
        .base      (rd_val),
        .pc        (pc_val),
        .offset    (mem_rdata),
        .sel_is_pc (sel_is_pc),
        .step_up   (step_up),
        .step_down (step_down),
        .pc_next   (pc_next),
        .index_ea  (index_ea)
    );

    opf_seq #(.W(W), .NREG(NREG), .SEL_W(SEL_W)) seq_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .spec_mode  (spec[SEL_W+2:SEL_W]),
        .spec_sel   (spec[SEL_W-1:0]),
        .rd_sel     (rd_sel),
        .rd_val     (rd_val),
        .pc_val     (pc_val),
        .step_up    (step_up),
        .step_down  (step_down),
        .pc_next    (pc_next),
        .index_ea   (index_ea),
        .mem_req    (mem_req),
        .mem_addr   (mem_addr),
        .mem_rvalid (mem_rvalid),
        .mem_rdata  (mem_rdata),
        .busy       (busy),
        .done       (done),
        .eff_addr   (eff_addr),
        .operand    (operand),
        .upd_en     (upd_en),
        .upd_sel    (upd_sel),
        .upd_data   (upd_data),
        .cur_mode   (cur_mode),
        .cur_sel    (cur_sel)
    );

    // R2: a direct-mode start completes next cycle with no memory read.
    p_direct_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && spec[SEL_W+2:SEL_W] == AM_REG) |=> (done && !mem_req));

    // R4 / R7: the stepping modes leave the register one word higher.
    p_autoinc_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (done && (cur_mode == AM_INC || cur_mode == AM_INCDEF))
            |-> cur_val == $past(cur_val) + W'(STEP));

    // R5: after a pre-decrement the register equals the address used.
    p_autodec_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (done && cur_mode == AM_DEC) |-> eff_addr == cur_val);

    // R8 / R9: the indexed modes move the program counter past the offset.
    p_pc_adv_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && (cur_mode == AM_IDX || cur_mode == AM_IDXDEF))
            |-> regs_all[PC_IDX] == $past(regs_all[PC_IDX]) + W'(STEP));

endmodule

// File: tb/opfetch_unit_tb_top.sv
module opfetch_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [5:0]  spec = '0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_sel = '0;
    logic [15:0] wr_data = '0;
    logic        mem_req;
    logic [15:0] mem_addr;
    logic        mem_rvalid = 1'b0;
    logic [15:0] mem_rdata = '0;
    logic        busy;
    logic        done;
    logic [15:0] eff_addr;
    logic [15:0] operand;

    int n_tests = 0;
    int n_fail  = 0;
    int lat_cfg = 1;

    logic [15:0] ref_rf [8];
    logic [15:0] mem_over [int];
    logic [15:0] exp_q [$];
    string       cur_tag = "R1";
    logic        exp_done = 1'b0;
    logic        got_done = 1'b0;
    logic [15:0] exp_op, exp_ea;

    logic        pend = 1'b0;
    logic [15:0] paddr = '0;
    int          wcnt = 0;

    always #2 clk = ~clk;

    opfetch_unit dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .spec(spec),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .busy(busy), .done(done), .eff_addr(eff_addr), .operand(operand)
    );

    function automatic logic [15:0] mword(input logic [15:0] a);
        int k = int'({a[15:1], 1'b0});
        logic [15:0] v;
        if (mem_over.exists(k)) return mem_over[k];
        v = 16'(k * 5 + 258);
        return {v[15:1], 1'b0};
    endfunction

    task automatic chk(input string tag, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // Memory model: one pending read, answered after lat_cfg idle cycles.
    always @(posedge clk) begin
        mem_rvalid <= 1'b0;
        if (pend) begin
            if (wcnt == 0) begin
                mem_rvalid <= 1'b1;
                mem_rdata  <= mword(paddr);
                pend       <= 1'b0;
            end else begin
                wcnt <= wcnt - 1;
            end
        end else if (rst_n && mem_req) begin
            pend  <= 1'b1;
            paddr <= mem_addr;
            wcnt  <= lat_cfg;
        end
    end

    // Per-clock comparison of requests and completions with the model.
    always @(negedge clk) begin
        logic [15:0] e;
        if (rst_n) begin
            if (mem_req) begin
                if (pend) chk("R12", "request while read pending", 16'd1, 16'd0);
                if (exp_q.size() == 0) begin
                    chk("R12", "unexpected read address", mem_addr, 16'hxxxx);
                end else begin
                    e = exp_q.pop_front();
                    chk(cur_tag, "read address", mem_addr, e);
                end
            end
            if (done) begin
                if (!exp_done) begin
                    chk("R12", "unexpected done", 16'd1, 16'd0);
                end else begin
                    chk(cur_tag, "operand", operand, exp_op);
                    chk(cur_tag, "eff_addr", eff_addr, exp_ea);
                    exp_done = 1'b0;
                    got_done = 1'b1;
                end
            end
        end
    end

    function automatic string tag_of(input int m, input int r);
        case (m)
            0: return "R2";
            1: return "R3";
            2: return "R4";
            4: return "R6";
            5: return "R7";
            6: return "R5";
            3: return (r == 7) ? "R10" : "R8";
            default: return (r == 7) ? "R10" : "R9";
        endcase
    endfunction

    // inject: 0 none, 1 start pulse while busy, 2 load pulse while busy.
    task automatic do_op(input int m, input int r, input string tag, input int inject);
        logic [15:0] a, p, off, base, pc;
        logic [15:0] new_r;
        logic        upd_r, upd_pc;
        upd_r = 1'b0; upd_pc = 1'b0; new_r = '0;
        pc = ref_rf[7];
        case (m)
            0: begin exp_op = ref_rf[r]; exp_ea = '0; end
            1, 2, 6: begin
                a = (m == 6) ? ref_rf[r] - 16'd2 : ref_rf[r];
                exp_q.push_back(a);
                exp_op = mword(a); exp_ea = a;
                if (m != 1) begin
                    upd_r = 1'b1;
                    new_r = (m == 2) ? ref_rf[r] + 16'd2 : a;
                end
            end
            4, 5: begin
                a = ref_rf[r];
                p = mword(a);
                exp_q.push_back(a); exp_q.push_back(p);
                exp_op = mword(p); exp_ea = p;
                if (m == 5) begin upd_r = 1'b1; new_r = ref_rf[r] + 16'd2; end
            end
            default: begin
                off = mword(pc);
                exp_q.push_back(pc);
                base = (r == 7) ? pc + 16'd2 : ref_rf[r];
                a = base + off;
                exp_q.push_back(a);
                if (m == 7) begin
                    p = mword(a);
                    exp_q.push_back(p);
                    exp_op = mword(p); exp_ea = p;
                end else begin
                    exp_op = mword(a); exp_ea = a;
                end
                upd_pc = 1'b1;
            end
        endcase
        cur_tag  = tag;
        exp_done = 1'b1;
        got_done = 1'b0;
        @(negedge clk);
        start = 1'b1;
        spec  = {3'(m), 3'(r)};
        @(negedge clk);
        start = 1'b0;
        #1;
        if (m == 0) chk("R2", "done one cycle after start", {15'd0, got_done}, 16'd1);
        else        chk("R12", "busy after start", {15'd0, busy}, 16'd1);
        for (int i = 0; i < 4000 && !got_done; i++) begin
            @(negedge clk);
            #1;
            if (inject == 1 && i == 1) begin start = 1'b1; spec = 6'o00; end
            if (inject == 1 && i == 2) start = 1'b0;
            if (inject == 2 && i == 1) begin wr_en = 1'b1; wr_sel = 3'(r); wr_data = 16'hDEAD; end
            if (inject == 2 && i == 2) wr_en = 1'b0;
        end
        start = 1'b0;
        wr_en = 1'b0;
        if (!got_done) chk(tag, "done never raised", 16'd0, 16'd1);
        chk(tag, "all reads issued", 16'(exp_q.size()), 16'd0);
        exp_q.delete();
        exp_done = 1'b0;
        if (upd_r)  ref_rf[r] = new_r;
        if (upd_pc) ref_rf[7] = pc + 16'd2;
    endtask

    task automatic load_reg(input int r, input logic [15:0] v);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = 3'(r); wr_data = v;
        @(negedge clk);
        wr_en = 1'b0;
        ref_rf[r] = v;
    endtask

    task automatic summary;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        for (int i = 0; i < 8; i++) ref_rf[i] = '0;
        mem_over[128]    = 16'd380;
        mem_over[380]    = 16'hBEEF;
        mem_over[16'h1000] = 16'h0010;
        mem_over[16'h1002] = 16'hFFF0;
        mem_over[16'h1004] = 16'h0020;
        mem_over[16'h1006] = 16'h0004;
        mem_over[16'h0204] = 16'h0444;

        repeat (4) @(negedge clk);
        chk("R1", "done in reset", {15'd0, done}, 16'd0);
        chk("R1", "busy in reset", {15'd0, busy}, 16'd0);
        chk("R1", "mem_req in reset", {15'd0, mem_req}, 16'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "done after reset", {15'd0, done}, 16'd0);
        chk("R1", "mem_req after reset", {15'd0, mem_req}, 16'd0);
        for (int r = 0; r < 8; r++) do_op(0, r, "R1", 0);

        load_reg(1, 16'h0200);
        load_reg(2, 16'h0300);
        load_reg(3, 16'h0040);
        load_reg(4, 16'd128);
        load_reg(5, 16'h0500);
        load_reg(6, 16'h0600);
        load_reg(7, 16'h1000);

        // Fast memory phase.
        lat_cfg = 0;
        do_op(1, 1, tag_of(1, 1), 0);
        do_op(0, 1, "R3", 0);
        do_op(2, 4, tag_of(2, 4), 0);
        do_op(0, 4, "R4", 0);
        load_reg(4, 16'd128);
        do_op(5, 4, tag_of(5, 4), 0);
        do_op(0, 4, "R7", 0);
        do_op(4, 4, tag_of(4, 4), 0);
        do_op(0, 4, "R6", 0);

        // Slower memory phase.
        lat_cfg = 2;
        do_op(6, 5, tag_of(6, 5), 0);
        do_op(0, 5, "R5", 0);
        do_op(6, 0, "R5", 0);
        do_op(0, 0, "R5", 0);
        do_op(3, 3, tag_of(3, 3), 0);
        do_op(0, 7, "R8", 0);
        do_op(3, 2, "R8", 0);
        do_op(3, 7, tag_of(3, 7), 0);
        do_op(0, 7, "R10", 0);
        do_op(7, 1, tag_of(7, 1), 0);
        do_op(7, 7, tag_of(7, 7), 0);
        do_op(0, 7, "R9", 0);
        do_op(2, 7, "R4", 0);
        do_op(0, 7, "R4", 0);

        // Busy-time stimulus that must be ignored.
        lat_cfg = 6;
        do_op(1, 2, "R11", 1);
        do_op(4, 6, "R11", 2);
        do_op(0, 6, "R11", 0);
        do_op(7, 3, "R11", 2);
        do_op(0, 3, "R11", 0);
        do_op(5, 1, "R11", 1);
        do_op(0, 1, "R11", 0);

        lat_cfg = 1;
        for (int m = 0; m < 8; m++) do_op(m, (m + 3) % 8, tag_of(m, (m + 3) % 8), 0);
        for (int r = 0; r < 8; r++) do_op(0, r, "R12", 0);

        repeat (4) @(negedge clk);
        summary();
        $finish;
    end

endmodule